// File: doc/BRIEF.md
# Paged Memory Window Access Controller

This block lets a processor with a narrow byte-wide register interface reach two large byte-addressed memory devices through a single data register. Software first sets an 11-bit page number by writing two page registers: a low byte and a 3-bit high part. It then reads or writes the memory data register over and over. Each access reaches the next byte of the page, because an internal 7-bit offset counter supplies the low address bits and advances when an access ends.

The block drives a 17-bit device address, one chip select per device and registered write and read strobes. Data itself passes straight between the processor bus and the devices, so the block never holds it. Bit 10 of the page picks the device: pages 0 to 1023 go to device 0 and pages 1024 to 2047 go to device 1. A power-fail inhibit input blocks every memory access while it is high.

Top module: `pagewin_ctrl`

## Requirements
- R1: After synchronous reset, `mem_addr` is 0, `mem_cs` is 2'b00, and `mem_we` and `mem_oe` are 0.
- R2: A cycle with `sel_lo` and `wr_en` high loads `din[7:0]` into page bits 7:0 and clears the offset to 0. Both are visible on the next cycle.
- R3: A cycle with `sel_hi` and `wr_en` high loads `din[2:0]` into page bits 10:8 and ignores `din[7:3]`. It leaves the offset unchanged.
- R4: `mem_addr` is {page[9:0], offset[6:0]}. Bits 16:7 carry the page bits and bits 6:0 carry the offset.
- R5: One cycle after an access cycle starts, exactly one chip select is high. An access cycle is `sel_mem` high with `wr_en` or `rd_en` high. The chip select is `mem_cs[0]` when page bit 10 is 0 and `mem_cs[1]` when it is 1. Both chip selects are low one cycle after the access ends.
- R6: `mem_we` follows `wr_en`, and `mem_oe` follows `rd_en` with `wr_en` low. Both act only during an access cycle, with one cycle of delay.
- R7: The offset advances by exactly one when an access cycle ends, however many cycles the access was held. The new value is visible one cycle after the access inputs drop.
- R8: The offset wraps from 127 to 0 and leaves the page bits unchanged.
- R9: While `inhibit` is high, both chip selects and both strobes stay low on the following cycle, and a blocked access does not advance the offset.
- R10: `wr_en` or `rd_en` without `sel_mem` drives no chip select and does not advance the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_lo | input | 1 | Low page register select |
| sel_hi | input | 1 | High page register select |
| sel_mem | input | 1 | Memory data register select |
| wr_en | input | 1 | Processor write strobe, active high |
| rd_en | input | 1 | Processor read strobe, active high |
| din | input | 8 | Processor data bus, used for page loads |
| inhibit | input | 1 | Power-fail access block, active high |
| mem_addr | output | 17 | Device address {page[9:0], offset} |
| mem_cs | output | 2 | Per-device chip selects, active high |
| mem_we | output | 1 | Registered device write strobe |
| mem_oe | output | 1 | Registered device read strobe |

## Verification
Accesses are run in short write bursts, as single reads, as one access held for several cycles, and as a full run of 128 accesses. The held access separates counting access ends from counting cycles. The full run shows the wrap and confirms that the page bits survive it. A write-then-read-back pass runs through a bench memory model on pages that differ only in bit 10. It shows that the device select and the address lines keep the two devices apart. Further tests raise the access strobes without the data select, or with inhibit high, and then rewrite only the high page byte. Each of these must leave the offset at the value it had before.

// File: rtl/pagewin_pkg.sv
package pagewin_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int LO_W_DEF   = 8;
  localparam int HI_W_DEF   = 3;
  localparam int OFS_W_DEF  = 7;
  localparam int SEL_W_DEF  = 1;

  typedef struct packed {
    logic we;
    logic oe;
  } strobe_t;
endpackage

// File: rtl/pagewin_pagereg.sv
module pagewin_pagereg #(
  parameter int DATA_W = pagewin_pkg::DATA_W_DEF,
  parameter int LO_W   = pagewin_pkg::LO_W_DEF,
  parameter int HI_W   = pagewin_pkg::HI_W_DEF,
  localparam int PAGE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] din,
  output logic [PAGE_W-1:0] page_o
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (ld_lo) lo_q <= din[LO_W-1:0];
      if (ld_hi) hi_q <= din[HI_W-1:0];
    end
  end

  assign page_o = {hi_q, lo_q};
endmodule

// File: rtl/pagewin_offset.sv
module pagewin_offset #(
  parameter int OFS_W = pagewin_pkg::OFS_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             act,
  input  logic             inhibit,
  output logic [OFS_W-1:0] ofs_o
);
  logic             act_q;
  logic             step;
  logic [OFS_W-1:0] cnt_q;

  // trailing edge of the access cycle, suppressed during power fail
  assign step = act_q & ~act & ~inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act;
      if (clr)       cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ofs_o = cnt_q;
endmodule

// File: rtl/pagewin_decode.sv
module pagewin_decode #(
  parameter int SEL_W = pagewin_pkg::SEL_W_DEF,
  localparam int NUM_DEV = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [SEL_W-1:0]   dev,
  output logic [NUM_DEV-1:0] cs_o,
  output pagewin_pkg::strobe_t strb_o
);
  pagewin_pkg::strobe_t strb_q;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    logic cs_q;
    always_ff @(posedge clk) begin
      if (rst) cs_q <= 1'b0;
      else     cs_q <= act && (dev == SEL_W'(i));
    end
    assign cs_o[i] = cs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= '0;
    end else begin
      strb_q.we <= act & wr_en;
      strb_q.oe <= act & rd_en & ~wr_en;
    end
  end

  assign strb_o = strb_q;
endmodule

// File: rtl/pagewin_ctrl.sv
module pagewin_ctrl #(
  parameter int DATA_W = pagewin_pkg::DATA_W_DEF,
  parameter int LO_W   = pagewin_pkg::LO_W_DEF,
  parameter int HI_W   = pagewin_pkg::HI_W_DEF,
  parameter int OFS_W  = pagewin_pkg::OFS_W_DEF,
  parameter int SEL_W  = pagewin_pkg::SEL_W_DEF,
  localparam int PAGE_W  = LO_W + HI_W,
  localparam int ADDR_W  = PAGE_W - SEL_W + OFS_W,
  localparam int NUM_DEV = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_lo,
  input  logic               sel_hi,
  input  logic               sel_mem,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  din,
  input  logic               inhibit,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_cs,
  output logic               mem_we,
  output logic               mem_oe
);
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic              ld_lo;
  logic              ld_hi;
  logic              act;
  pagewin_pkg::strobe_t strb;

  assign ld_lo = sel_lo & wr_en;
  assign ld_hi = sel_hi & wr_en;
  assign act   = sel_mem & (wr_en | rd_en) & ~inhibit;

  pagewin_pagereg #(.DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W)) u_page (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .din(din), .page_o(page)
  );

  pagewin_offset #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst(rst), .clr(ld_lo), .act(act), .inhibit(inhibit), .ofs_o(ofs)
  );

  pagewin_decode #(.SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst(rst), .act(act), .wr_en(wr_en), .rd_en(rd_en),
    .dev(page[PAGE_W-1 -: SEL_W]), .cs_o(mem_cs), .strb_o(strb)
  );

  assign mem_addr = {page[PAGE_W-SEL_W-1:0], ofs};
  assign mem_we   = strb.we;
  assign mem_oe   = strb.oe;
endmodule

// File: rtl/pagewin_checker.sv
module pagewin_checker #(
  parameter int LO_W  = pagewin_pkg::LO_W_DEF,
  parameter int OFS_W = pagewin_pkg::OFS_W_DEF,
  parameter int ADDR_W = 17,
  parameter int NUM_DEV = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               sel_lo,
  input logic               sel_hi,
  input logic               wr_en,
  input logic [7:0]         din,
  input logic               inhibit,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [NUM_DEV-1:0] mem_cs,
  input logic               mem_we,
  input logic               mem_oe
);
  logic [OFS_W-1:0] ofs;
  assign ofs = mem_addr[OFS_W-1:0];

  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_cs));

  assert_inhibit_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (mem_cs == '0 && !mem_we && !mem_oe));

  assert_strobe_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_oe) |-> (mem_cs != '0));

  assert_ofs_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ofs) |-> (ofs == OFS_W'($past(ofs) + 1'b1) || ofs == '0));

  assert_lo_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_lo && wr_en) |=> (ofs == '0 && mem_addr[OFS_W +: LO_W] == $past(din[LO_W-1:0])));

  assert_hi_keeps_ofs_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_hi && wr_en && !sel_lo && mem_cs == '0) |=> $stable(ofs));
endmodule

bind pagewin_ctrl pagewin_checker u_chk (
  .clk(clk), .rst(rst), .sel_lo(sel_lo), .sel_hi(sel_hi), .wr_en(wr_en),
  .din(din), .inhibit(inhibit), .mem_addr(mem_addr), .mem_cs(mem_cs),
  .mem_we(mem_we), .mem_oe(mem_oe)
);

// File: tb/pagewin_ctrl_test.sv
module pagewin_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        sel_lo, sel_hi, sel_mem, wr_en, rd_en, inhibit;
  logic [7:0]  din;
  logic [16:0] mem_addr;
  logic [1:0]  mem_cs;
  logic        mem_we, mem_oe;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_model [int];

  // sampled results of the last access
  logic [1:0]  s_cs;
  logic [16:0] s_addr;
  logic        s_we, s_oe;
  logic [7:0]  s_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pagewin_ctrl uut (
    .clk(clk), .rst(rst), .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_mem(sel_mem),
    .wr_en(wr_en), .rd_en(rd_en), .din(din), .inhibit(inhibit),
    .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe)
  );

  // two-device memory model, keyed by {device, address}
  always @(negedge clk) begin
    if (mem_we && mem_cs != 2'b00)
      mem_model[{14'd0, mem_cs[1], mem_addr}] = din;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_lo = 0; sel_hi = 0; sel_mem = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic write_lo(input logic [7:0] v);
    @(negedge clk); sel_lo = 1; wr_en = 1; din = v;
    @(negedge clk); idle();
  endtask

  task automatic write_hi(input logic [7:0] v);
    @(negedge clk); sel_hi = 1; wr_en = 1; din = v;
    @(negedge clk); idle();
  endtask

  // one data-register access held for 'hold' cycles; returns after the offset step is visible
  task automatic access(input bit is_wr, input int hold, input logic [7:0] v);
    @(negedge clk);
    sel_mem = 1; wr_en = is_wr; rd_en = !is_wr; din = v;
    repeat (hold) @(negedge clk);
    s_cs = mem_cs; s_addr = mem_addr; s_we = mem_we; s_oe = mem_oe;
    s_rdata = mem_model.exists({14'd0, mem_cs[1], mem_addr}) ?
              mem_model[{14'd0, mem_cs[1], mem_addr}] : 8'h00;
    idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 addr", mem_addr, 0);
    check("R1 cs", mem_cs, 0);
    check("R1 we", mem_we, 0);
    check("R1 oe", mem_oe, 0);
  endtask

  task automatic t_page_and_burst();
    write_lo(8'h5A);
    check("R2 page lo", mem_addr[16:7], 10'h05A);
    check("R2 ofs cleared", mem_addr[6:0], 0);
    write_hi(8'hFD); // only 3'b101 is kept: page = 0x55A
    check("R3 hi bits", mem_addr[16:7], 10'h15A);
    for (int i = 0; i < 3; i++) begin
      access(1, 1, 8'h10 + 8'(i));
      check("R5 cs dev1", s_cs, 2'b10);
      check("R6 we", s_we, 1);
      check("R6 oe", s_oe, 0);
      check("R4 addr", s_addr, {10'h15A, 7'(i)});
    end
    check("R5 cs drop", mem_cs, 0);
    check("R7 ofs after burst", mem_addr[6:0], 3);
    write_hi(8'h00);
    check("R3 hi keeps ofs", mem_addr[6:0], 3);
    access(0, 1, 8'h00);
    check("R5 cs dev0", s_cs, 2'b01);
    check("R6 oe", s_oe, 1);
    check("R6 we on read", s_we, 0);
    check("R7 ofs after read", mem_addr[6:0], 4);
  endtask

  task automatic t_long_hold();
    access(1, 5, 8'h77);
    check("R7 held access ofs", s_addr[6:0], 4);
    check("R7 single step", mem_addr[6:0], 5);
  endtask

  task automatic t_wrap();
    write_lo(8'h33);
    write_hi(8'h02); // page 0x233
    for (int i = 0; i < 128; i++) begin
      access(0, 1, 8'h00);
      if (i == 127) check("R8 last ofs", s_addr[6:0], 127);
    end
    check("R8 wrapped ofs", mem_addr[6:0], 0);
    check("R8 page kept", mem_addr[16:7], 10'h233);
  endtask

  task automatic t_inhibit();
    access(1, 1, 8'h00); // ofs = 1
    inhibit = 1;
    access(1, 3, 8'hEE);
    check("R9 cs blocked", s_cs, 0);
    check("R9 we blocked", s_we, 0);
    check("R9 ofs held", mem_addr[6:0], 1);
    inhibit = 0;
  endtask

  task automatic t_no_select();
    @(negedge clk); wr_en = 1; rd_en = 1;
    @(negedge clk);
    check("R10 no cs", mem_cs, 0);
    idle();
    @(negedge clk);
    check("R10 ofs held", mem_addr[6:0], 1);
  endtask

  task automatic t_readback();
    write_hi(8'h01); write_lo(8'h23); // page 0x123, device 0
    for (int i = 0; i < 4; i++) access(1, 1, 8'hA0 + 8'(i));
    write_hi(8'h05); write_lo(8'h23); // page 0x523, device 1, same low bits
    for (int i = 0; i < 4; i++) access(1, 1, 8'hC0 + 8'(i));
    write_hi(8'h01); write_lo(8'h23);
    for (int i = 0; i < 4; i++) begin
      access(0, 1, 8'h00);
      check("R4 readback dev0", s_rdata, 8'hA0 + 8'(i));
    end
    write_hi(8'h05); write_lo(8'h23);
    for (int i = 0; i < 4; i++) begin
      access(0, 1, 8'h00);
      check("R5 readback dev1", s_rdata, 8'hC0 + 8'(i));
    end
  endtask

  initial begin
    idle(); inhibit = 0; din = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_page_and_burst();
    t_long_hold();
    t_wrap();
    t_inhibit();
    t_no_select();
    t_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule